// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block sits between fifteen interrupt request lines and a small 8-bit CPU. Each source can be switched on or off with its own enable bit, and all sources together with a master enable input. Each source is also placed in one of two priority levels by its own priority bit. On every machine-cycle strobe the arbiter looks at the gated requests and picks one winner. It then holds that winner as an offer (valid flag, vector address, level) until the CPU acknowledges it.

Two in-service flags record which levels are currently being serviced, and this is what makes nesting work. While a low-level routine runs, only a high-level request can be offered. While a high-level routine runs, nothing can be offered. A return pulse from the CPU releases the innermost active level.

The enable and priority vectors are loaded through plain write ports. Bit n of each vector belongs to source index n. The source indices are: X0=0, T0=1, X1=2, T1=3, S0=4, S1=5, T2=6, X2=7, X3=8, X4=9, X5=10, X6=11, X7=12, X8=13, ADC=14.

Top module: `irq_arbiter`

## Requirements
- R1: After reset there is no offer (irqValid=0), both in-service flags are 0, and every enable and priority bit is 0, so requests raised before any configuration write are never offered.
- R2: A request is a candidate only when its enable bit is 1 and masterEn is 1.
- R3: The offered vector is 0x0003 + 8 × source index, so X0=0x0003, T0=0x000B, X1=0x0013 and ADC=0x0073.
- R4: When candidates of both levels are pending, a high-level candidate (priority bit 1, irqLevel=1) wins over any low-level one.
- R5: Within one level the winner follows the fixed poll order, first to last: X0, S1, X5, T0, T2, X6, X1, X2, X7, T1, X3, X8, S0, X4, ADC.
- R6: Requests are sampled only on a clock edge where cycleStrobe is 1 and no offer is held. The offer is visible right after that edge. Without a strobe, no offer appears.
- R7: While irqValid is 1 and no acknowledge arrives, the vector and level stay unchanged, whatever the requests or strobes do.
- R8: An irqAck while irqValid=1 clears irqValid and sets the in-service flag of the offered level (svcFlags bit 0 = low, bit 1 = high).
- R9: While the low flag is set, only high-level candidates can be offered.
- R10: While the high flag is set, no candidate is offered.
- R11: A retPulse clears the high flag if it is set, and otherwise clears the low flag. Arbitration in the same cycle uses the flags as they were before that edge.
- R12: An irqAck while irqValid=0 leaves the flags and the offer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleStrobe | input | 1 | Machine-cycle sample strobe |
| reqIn | input | 15 | Raw request lines, bit n = source index n |
| enWe | input | 1 | Write strobe for the enable vector |
| enData | input | 15 | New enable vector |
| prioWe | input | 1 | Write strobe for the priority vector |
| prioData | input | 15 | New priority vector (1 = high) |
| masterEn | input | 1 | Master enable for all sources |
| irqAck | input | 1 | CPU acknowledge of the current offer |
| retPulse | input | 1 | Return-from-interrupt pulse |
| irqValid | output | 1 | An offer is pending |
| irqVector | output | 16 | Vector address of the offer |
| irqLevel | output | 1 | Level of the offer (1 = high) |
| svcFlags | output | 2 | In-service flags: bit 0 low, bit 1 high |

## Verification
Every result of this block is due at the first rising edge that sees its cause:
- an offer appears right after the edge that samples a strobe;
- the in-service flags change right after the edge that carries an acknowledge or a return pulse;
- a configuration write takes effect for the strobe that follows it.

The bench drives inputs on the falling edge. It reads outputs one nanosecond after the next rising edge. A reference model advances in step with each driven cycle, and every compare is made at that point.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic loadOffer;
    logic takeAck;
    logic doReturn;
  } ctrlStrobes_t;

  // Source index polled at rank r: interleave groups of 'stride' sources
  function automatic int pollIdx(int r, int stride, int groups);
    return (r % groups) * stride + (r / groups);
  endfunction

endpackage

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC     = 15,
  parameter int POLL_STRIDE = 5,
  parameter int VEC_W       = 16,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STEP    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               enWe,
  input  logic [NUM_SRC-1:0] enData,
  input  logic               prioWe,
  input  logic [NUM_SRC-1:0] prioData,
  input  logic               masterEn,
  input  logic               svcLow,
  input  logic               svcHigh,
  input  ctrlStrobes_t       strobes,
  output logic               candFound,
  output logic               offerLevel,
  output logic [VEC_W-1:0]   offerVector
);

  localparam int IDX_W       = $clog2(NUM_SRC);
  localparam int POLL_GROUPS = NUM_SRC / POLL_STRIDE;

  logic [NUM_SRC-1:0] enReg, prioReg, gated;
  logic [NUM_SRC-1:0] hiByRank, loByRank;
  logic [IDX_W-1:0]   hiIdx, loIdx, candIdx, offerIdx;
  logic               hiFound, loFound, allowHigh, allowLow, candLvl, offerLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= '0;
      prioReg <= '0;
    end else begin
      if (enWe)   enReg   <= enData;
      if (prioWe) prioReg <= prioData;
    end
  end

  assign gated = reqIn & enReg & {NUM_SRC{masterEn}};

  // Permute requests into poll-rank order, split by level
  for (genvar r = 0; r < NUM_SRC; r++) begin : g_rank
    localparam int SrcIdx = pollIdx(r, POLL_STRIDE, POLL_GROUPS);
    assign hiByRank[r] = gated[SrcIdx] &  prioReg[SrcIdx];
    assign loByRank[r] = gated[SrcIdx] & ~prioReg[SrcIdx];
  end

  // First set rank wins in each level
  always_comb begin
    hiFound = 1'b0;
    loFound = 1'b0;
    hiIdx   = '0;
    loIdx   = '0;
    for (int r = NUM_SRC - 1; r >= 0; r--) begin
      if (hiByRank[r]) begin
        hiFound = 1'b1;
        hiIdx   = IDX_W'(pollIdx(r, POLL_STRIDE, POLL_GROUPS));
      end
      if (loByRank[r]) begin
        loFound = 1'b1;
        loIdx   = IDX_W'(pollIdx(r, POLL_STRIDE, POLL_GROUPS));
      end
    end
  end

  assign allowHigh = !svcHigh;
  assign allowLow  = !svcHigh && !svcLow;
  assign candLvl   = hiFound && allowHigh;
  assign candFound = candLvl || (loFound && allowLow);
  assign candIdx   = candLvl ? hiIdx : loIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offerIdx <= '0;
      offerLvl <= 1'b0;
    end else if (strobes.loadOffer) begin
      offerIdx <= candIdx;
      offerLvl <= candLvl;
    end
  end

  assign offerLevel  = offerLvl;
  assign offerVector = VEC_W'(VEC_BASE) + VEC_W'(offerIdx) * VEC_W'(VEC_STEP);

endmodule

// File: rtl/irq_arb_control.sv
module irq_arb_control
  import irq_arb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cycleStrobe,
  input  logic         irqAck,
  input  logic         retPulse,
  input  logic         candFound,
  input  logic         offerLevel,
  output ctrlStrobes_t strobes,
  output logic         offerValid,
  output logic [1:0]   svcFlags
);

  logic [1:0] svcNext;

  always_comb begin
    strobes.loadOffer = cycleStrobe && !offerValid && candFound;
    strobes.takeAck   = irqAck && offerValid;
    strobes.doReturn  = retPulse;
  end

  always_comb begin
    svcNext = svcFlags;
    if (strobes.doReturn) begin
      if (svcFlags[1]) svcNext[1] = 1'b0;
      else             svcNext[0] = 1'b0;
    end
    if (strobes.takeAck) svcNext[offerLevel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offerValid <= 1'b0;
      svcFlags   <= 2'b00;
    end else begin
      svcFlags <= svcNext;
      if (strobes.loadOffer)    offerValid <= 1'b1;
      else if (strobes.takeAck) offerValid <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC     = 15,
  parameter int POLL_STRIDE = 5,
  parameter int VEC_W       = 16,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STEP    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cycleStrobe,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               enWe,
  input  logic [NUM_SRC-1:0] enData,
  input  logic               prioWe,
  input  logic [NUM_SRC-1:0] prioData,
  input  logic               masterEn,
  input  logic               irqAck,
  input  logic               retPulse,
  output logic               irqValid,
  output logic [VEC_W-1:0]   irqVector,
  output logic               irqLevel,
  output logic [1:0]         svcFlags
);

  ctrlStrobes_t strobes;
  logic         candFound;

  irq_arb_datapath #(
    .NUM_SRC(NUM_SRC), .POLL_STRIDE(POLL_STRIDE), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn),
    .enWe(enWe), .enData(enData), .prioWe(prioWe), .prioData(prioData),
    .masterEn(masterEn), .svcLow(svcFlags[0]), .svcHigh(svcFlags[1]),
    .strobes(strobes), .candFound(candFound),
    .offerLevel(irqLevel), .offerVector(irqVector)
  );

  irq_arb_control u_ctl (
    .clk(clk), .rstN(rstN), .cycleStrobe(cycleStrobe),
    .irqAck(irqAck), .retPulse(retPulse),
    .candFound(candFound), .offerLevel(irqLevel),
    .strobes(strobes), .offerValid(irqValid), .svcFlags(svcFlags)
  );

endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
  parameter int VEC_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cycleStrobe,
  input logic             irqAck,
  input logic             retPulse,
  input logic             irqValid,
  input logic [VEC_W-1:0] irqVector,
  input logic             irqLevel,
  input logic [1:0]       svcFlags
);

  // R7: offer frozen until acknowledged
  a_r7_offer_held: assert property (@(posedge clk) disable iff (!rstN)
    irqValid && !irqAck |=> irqValid && $stable(irqVector) && $stable(irqLevel));

  // R8: acknowledge drops the offer and marks the level in service
  a_r8_ack_high: assert property (@(posedge clk) disable iff (!rstN)
    irqValid && irqAck && irqLevel |=> !irqValid && svcFlags[1]);
  a_r8_ack_low: assert property (@(posedge clk) disable iff (!rstN)
    irqValid && irqAck && !irqLevel |=> !irqValid && svcFlags[0]);

  // R6: no strobe, no new offer
  a_r6_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !cycleStrobe && !irqValid |=> !irqValid);

  // R9: low in service admits only high offers
  a_r9_low_nesting: assert property (@(posedge clk) disable iff (!rstN)
    svcFlags[0] && !irqValid |=> !irqValid || irqLevel);

  // R10: high in service blocks every offer
  a_r10_high_blocks: assert property (@(posedge clk) disable iff (!rstN)
    svcFlags[1] && !irqValid |=> !irqValid);

  // R11: return releases high level first
  a_r11_return_high: assert property (@(posedge clk) disable iff (!rstN)
    retPulse && svcFlags[1] |=> !svcFlags[1] && (svcFlags[0] == $past(svcFlags[0])));

  // R12: stray acknowledge has no effect
  a_r12_stray_ack: assert property (@(posedge clk) disable iff (!rstN)
    irqAck && !irqValid && !retPulse |=> svcFlags == $past(svcFlags));

endmodule

bind irq_arbiter irq_arb_checker #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rstN(rstN), .cycleStrobe(cycleStrobe), .irqAck(irqAck),
  .retPulse(retPulse), .irqValid(irqValid), .irqVector(irqVector),
  .irqLevel(irqLevel), .svcFlags(svcFlags)
);

// File: tb/irq_arbiter_test.sv
`timescale 1ns/1ps
module irq_arbiter_test;

  localparam int N = 15;
  localparam int X0 = 0, T0 = 1, X1 = 2, T1 = 3, S0 = 4, S1 = 5, T2 = 6, X2 = 7;
  localparam int X3 = 8, X4 = 9, X5 = 10, X6 = 11, X7 = 12, X8 = 13, ADC = 14;
  localparam int POLL [N] = '{0, 5, 10, 1, 6, 11, 2, 7, 12, 3, 8, 13, 4, 9, 14};

  logic clk = 1'b0;
  logic rstN, cycleStrobe, enWe, prioWe, masterEn, irqAck, retPulse;
  logic [N-1:0] reqIn, enData, prioData;
  logic irqValid, irqLevel;
  logic [15:0] irqVector;
  logic [1:0] svcFlags;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model state
  logic [N-1:0] mEn, mPrio;
  logic mValid, mLvl;
  int mIdx;
  logic [1:0] mSvc;

  always #2 clk = ~clk;

  irq_arbiter uut (
    .clk(clk), .rstN(rstN), .cycleStrobe(cycleStrobe), .reqIn(reqIn),
    .enWe(enWe), .enData(enData), .prioWe(prioWe), .prioData(prioData),
    .masterEn(masterEn), .irqAck(irqAck), .retPulse(retPulse),
    .irqValid(irqValid), .irqVector(irqVector), .irqLevel(irqLevel),
    .svcFlags(svcFlags)
  );

  function automatic logic [N-1:0] bitOf(int i);
    return N'(1) << i;
  endfunction

  task automatic checkEq(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic compareAll(string tag);
    checkEq(tag, 32'(irqValid), 32'(mValid));
    if (mValid) begin
      checkEq(tag, 32'(irqVector), 32'(3 + 8 * mIdx));
      checkEq(tag, 32'(irqLevel), 32'(mLvl));
    end
    checkEq(tag, 32'(svcFlags), 32'(mSvc));
  endtask

  task automatic cfg(logic [N-1:0] en, logic [N-1:0] pr, logic mst);
    @(negedge clk);
    enWe = 1'b1; enData = en; prioWe = 1'b1; prioData = pr; masterEn = mst;
    @(posedge clk); #1;
    enWe = 1'b0; prioWe = 1'b0;
    mEn = en; mPrio = pr;
  endtask

  task automatic step(logic [N-1:0] req, logic stb, logic ack, logic ret, string tag);
    logic [N-1:0] g;
    logic [1:0] nSvc;
    int wIdx;
    logic wFound, wLvl;
    @(negedge clk);
    reqIn = req; cycleStrobe = stb; irqAck = ack; retPulse = ret;
    g = req & mEn & {N{masterEn}};
    wFound = 1'b0; wLvl = 1'b0; wIdx = 0;
    if (!mSvc[1]) begin
      for (int r = 0; r < N; r++)
        if (!wFound && g[POLL[r]] && mPrio[POLL[r]]) begin
          wFound = 1'b1; wLvl = 1'b1; wIdx = POLL[r];
        end
      if (!mSvc[0])
        for (int r = 0; r < N; r++)
          if (!wFound && g[POLL[r]] && !mPrio[POLL[r]]) begin
            wFound = 1'b1; wLvl = 1'b0; wIdx = POLL[r];
          end
    end
    nSvc = mSvc;
    if (ret) begin
      if (mSvc[1]) nSvc[1] = 1'b0; else nSvc[0] = 1'b0;
    end
    if (ack && mValid) nSvc[mLvl] = 1'b1;
    if (mValid) begin
      if (ack) mValid = 1'b0;
    end else if (stb && wFound) begin
      mValid = 1'b1; mIdx = wIdx; mLvl = wLvl;
    end
    mSvc = nSvc;
    @(posedge clk); #1;
    cycleStrobe = 1'b0; irqAck = 1'b0; retPulse = 1'b0;
    compareAll(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; cycleStrobe = 0; enWe = 0; prioWe = 0; masterEn = 1;
    irqAck = 0; retPulse = 0; reqIn = '0; enData = '0; prioData = '0;
    mEn = '0; mPrio = '0; mValid = 0; mLvl = 0; mIdx = 0; mSvc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    checkEq("R1 valid", 32'(irqValid), 0);
    checkEq("R1 svc", 32'(svcFlags), 0);
    step('1, 1, 0, 0, "R1 enables cleared");

    cfg('1, '0, 1'b0);
    step('1, 1, 0, 0, "R2 master off");
    cfg('1 & ~bitOf(X0), '0, 1'b1);
    step(bitOf(X0), 1, 0, 0, "R2 source disabled");

    cfg('1, '0, 1'b1);
    step('1, 0, 0, 0, "R6 no strobe");
    step('1, 1, 0, 0, "R5 all low");
    checkEq("R3 X0 vector", 32'(irqVector), 32'h0003);
    step('0, 0, 1, 0, "R8 ack low");
    step('0, 0, 0, 1, "R11 release low");

    step(bitOf(T2) | bitOf(X1) | bitOf(T0), 1, 0, 0, "R5 timers");
    checkEq("R3 T0 vector", 32'(irqVector), 32'h000B);
    step('0, 0, 1, 0, "R8");
    step('0, 0, 0, 1, "R11");

    step(bitOf(X7) | bitOf(X1), 1, 0, 0, "R5 X1 over X7");
    step(bitOf(X0), 1, 0, 0, "R7 hold");
    checkEq("R7 vector", 32'(irqVector), 32'h0013);
    step('0, 0, 1, 0, "R8");
    step('0, 0, 0, 1, "R11");

    cfg('1, bitOf(ADC), 1'b1);
    step(bitOf(X0) | bitOf(ADC), 1, 0, 0, "R4 high wins");
    checkEq("R3 ADC vector", 32'(irqVector), 32'h0073);
    checkEq("R4 level", 32'(irqLevel), 1);
    step('0, 0, 1, 0, "R8 ack high");
    step('1, 1, 0, 0, "R10 blocked");
    step('0, 0, 0, 1, "R11 release high");

    step(bitOf(X0), 1, 0, 0, "R9 setup");
    step('0, 0, 1, 0, "R8");
    step(bitOf(X3), 1, 0, 0, "R9 low blocked");
    step(bitOf(ADC) | bitOf(X3), 1, 0, 0, "R9 high nests");
    step('0, 0, 1, 0, "R8 nested");
    checkEq("R8 both flags", 32'(svcFlags), 3);
    step('0, 0, 0, 1, "R11 high first");
    checkEq("R11 low kept", 32'(svcFlags), 1);
    step('0, 0, 0, 1, "R11 then low");
    step('0, 0, 1, 0, "R12 stray ack");

    for (int i = 0; i < 600; i++) begin
      if (($urandom % 40) == 0)
        cfg(N'($urandom), N'($urandom), ($urandom % 8) != 0);
      step(N'($urandom) & N'($urandom), ($urandom % 2) == 1,
           ($urandom % 3) == 0, ($urandom % 4) == 0, "R5 random");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule